// File: doc/BRIEF.md
# Clip Rectangle Command Emitter

This block turns a request for a clipped drawing pass into a stream of 32-bit command words. A request carries a rectangle count together with three configuration words: the draw-rectangle opcode, a first drawing-setup word and a second drawing-setup word. For every rectangle it takes from its rectangle stream, the block first checks that the rectangle is usable. It then emits a six-word draw-rectangle packet and asks an outside agent to replay the caller's command buffer. It does not take the next rectangle until that replay has finished.

Coordinates are signed. The minimum corner is passed through unchanged. The maximum corner is converted from exclusive to inclusive by subtracting one from each axis. A request with a count of zero still makes one pass: the block emits no packet and requests a single replay. The first rectangle that fails the check ends the request. The error flag is raised and the block emits no further words and requests no further replays.

All three streams use a valid/ready style handshake, and every output is driven only from registered state. The word stream also marks the last word of each packet.

Top module: `clip_rect_emitter`

## Requirements
- R1: After reset the block is idle: busy, done, error, rectangle ready, word valid and replay request are all low.
- R2: A rectangle is rejected when x2 <= x1, when y2 <= y1, when x2 <= 0 or when y2 <= 0, all compared as signed two's-complement coordinates. Any other rectangle is accepted.
- R3: For each accepted rectangle the block emits exactly six words in this order: opcode, first setup word, minimum corner, maximum corner, second setup word, zero. The last-word marker is high on the sixth word only.
- R4: The minimum-corner word carries x1 in bits [15:0] and y1 in bits [31:16].
- R5: The maximum-corner word carries x2-1 in bits [15:0] and y2-1 in bits [31:16], each truncated to the coordinate width.
- R6: After the sixth word of a packet the block raises the replay request and holds it until replay done is seen. It takes no rectangle and emits no word in that time.
- R7: A request with count zero produces no packet and exactly one replay, then completes with no error.
- R8: The first rejected rectangle completes the request with the error flag high. No word or replay follows it. The flag stays high until the next start and clears when that start is taken.
- R9: While a word is offered and not accepted, the word and its valid stay unchanged.
- R10: A request with count N (N > 0) and only valid rectangles produces exactly N packets and N replays, then one done pulse.
- R11: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a request (taken only when idle) |
| rect_count_i | input | CNT_W | Number of rectangles in the request |
| opcode_i | input | 2*COORD_W | Draw-rectangle opcode word |
| setup_a_i | input | 2*COORD_W | First drawing-setup word |
| setup_b_i | input | 2*COORD_W | Second drawing-setup word |
| rect_valid_i | input | 1 | Rectangle on the inputs is valid |
| rect_ready_o | output | 1 | Block takes a rectangle |
| rect_x1_i | input | COORD_W | Left edge, signed |
| rect_y1_i | input | COORD_W | Top edge, signed |
| rect_x2_i | input | COORD_W | Right edge, exclusive, signed |
| rect_y2_i | input | COORD_W | Bottom edge, exclusive, signed |
| dw_valid_o | output | 1 | Command word valid |
| dw_ready_i | input | 1 | Sink takes the command word |
| dw_data_o | output | 2*COORD_W | Command word |
| dw_last_o | output | 1 | Last word of a packet |
| replay_req_o | output | 1 | Request a replay of the command buffer |
| replay_done_i | input | 1 | Replay finished |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse when a request ends |
| error_o | output | 1 | Request ended on a rejected rectangle |

## Verification
The bench builds the block with 16-bit coordinates and a 3-bit count. A seven-rectangle request is therefore the largest count, and it fits a short run, while a stray start of count seven during a busy request can be told apart from the real one. Using 16-bit coordinates places the corner fields at exactly the bit positions in R4 and R5. Negative coordinates then exercise the signed comparisons and the wrap of the inclusive corner.

// File: rtl/clip_emit_pkg.sv
package clip_emit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EMIT,
    ST_REPLAY
  } emit_state_e;

  // Word slots of one draw-rectangle packet; the order is the wire order.
  typedef enum logic [2:0] {
    SL_OPC  = 3'd0,
    SL_SETA = 3'd1,
    SL_MIN  = 3'd2,
    SL_MAX  = 3'd3,
    SL_SETB = 3'd4,
    SL_PAD  = 3'd5
  } pkt_slot_e;

  localparam pkt_slot_e LAST_SLOT = SL_PAD;

endpackage

// File: rtl/clip_rect_check.sv
module clip_rect_check #(
  parameter int COORD_W = 16
) (
  input  logic signed [COORD_W-1:0]   x1_i,
  input  logic signed [COORD_W-1:0]   y1_i,
  input  logic signed [COORD_W-1:0]   x2_i,
  input  logic signed [COORD_W-1:0]   y2_i,
  output logic                        ok_o,
  output logic        [2*COORD_W-1:0] min_word_o,
  output logic        [2*COORD_W-1:0] max_word_o
);

  localparam logic signed [COORD_W-1:0] ZERO = '0;
  localparam logic signed [COORD_W-1:0] ONE  = {{(COORD_W-1){1'b0}}, 1'b1};

  logic degenerate;
  logic [COORD_W-1:0] x_incl;
  logic [COORD_W-1:0] y_incl;

  always_comb begin
    degenerate = (x2_i <= x1_i) || (y2_i <= y1_i) ||
                 (x2_i <= ZERO) || (y2_i <= ZERO);
    ok_o       = !degenerate;
    x_incl     = x2_i - ONE;
    y_incl     = y2_i - ONE;
    min_word_o = {y1_i, x1_i};
    max_word_o = {y_incl, x_incl};
  end

endmodule

// File: rtl/clip_pkt_mux.sv
module clip_pkt_mux
  import clip_emit_pkg::*;
#(
  parameter int DW = 32
) (
  input  pkt_slot_e        slot_i,
  input  logic [DW-1:0]    opcode_i,
  input  logic [DW-1:0]    setup_a_i,
  input  logic [DW-1:0]    min_word_i,
  input  logic [DW-1:0]    max_word_i,
  input  logic [DW-1:0]    setup_b_i,
  output logic [DW-1:0]    word_o
);

  always_comb begin
    unique case (slot_i)
      SL_OPC:  word_o = opcode_i;
      SL_SETA: word_o = setup_a_i;
      SL_MIN:  word_o = min_word_i;
      SL_MAX:  word_o = max_word_i;
      SL_SETB: word_o = setup_b_i;
      default: word_o = '0;
    endcase
  end

endmodule

// File: rtl/clip_rect_emitter.sv
module clip_rect_emitter
  import clip_emit_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int CNT_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [CNT_W-1:0]       rect_count_i,
  input  logic [2*COORD_W-1:0]   opcode_i,
  input  logic [2*COORD_W-1:0]   setup_a_i,
  input  logic [2*COORD_W-1:0]   setup_b_i,
  input  logic                   rect_valid_i,
  output logic                   rect_ready_o,
  input  logic [COORD_W-1:0]     rect_x1_i,
  input  logic [COORD_W-1:0]     rect_y1_i,
  input  logic [COORD_W-1:0]     rect_x2_i,
  input  logic [COORD_W-1:0]     rect_y2_i,
  output logic                   dw_valid_o,
  input  logic                   dw_ready_i,
  output logic [2*COORD_W-1:0]   dw_data_o,
  output logic                   dw_last_o,
  output logic                   replay_req_o,
  input  logic                   replay_done_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   error_o
);

  localparam int DW = 2 * COORD_W;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  emit_state_e      state_q, state_d;
  pkt_slot_e        slot_q, slot_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [DW-1:0]    opc_q, seta_q, setb_q, min_q, max_q;
  logic             err_q, err_d;
  logic             done_q, done_d;

  logic             start_acc, rect_acc, word_acc, replay_acc;
  logic             cfg_en, rect_en, slot_en, remain_en;
  logic             rect_ok;
  logic [DW-1:0]    min_w, max_w;

  clip_rect_check #(.COORD_W(COORD_W)) u_check (
    .x1_i       (rect_x1_i),
    .y1_i       (rect_y1_i),
    .x2_i       (rect_x2_i),
    .y2_i       (rect_y2_i),
    .ok_o       (rect_ok),
    .min_word_o (min_w),
    .max_word_o (max_w)
  );

  clip_pkt_mux #(.DW(DW)) u_mux (
    .slot_i     (slot_q),
    .opcode_i   (opc_q),
    .setup_a_i  (seta_q),
    .min_word_i (min_q),
    .max_word_i (max_q),
    .setup_b_i  (setb_q),
    .word_o     (dw_data_o)
  );

  // Handshake qualifiers and clock enables
  always_comb begin
    start_acc  = (state_q == ST_IDLE)   && start_i;
    rect_acc   = (state_q == ST_FETCH)  && rect_valid_i;
    word_acc   = (state_q == ST_EMIT)   && dw_ready_i;
    replay_acc = (state_q == ST_REPLAY) && replay_done_i;
    cfg_en     = start_acc;
    rect_en    = rect_acc && rect_ok;
    slot_en    = rect_en || word_acc;
    remain_en  = start_acc || replay_acc;
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    remain_d = remain_q;
    err_d    = err_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          remain_d = rect_count_i;
          err_d    = 1'b0;
          state_d  = (rect_count_i == '0) ? ST_REPLAY : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rect_valid_i) begin
          if (rect_ok) begin
            slot_d  = SL_OPC;
            state_d = ST_EMIT;
          end else begin
            err_d   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_EMIT: begin
        if (dw_ready_i) begin
          if (slot_q == LAST_SLOT) begin
            state_d = ST_REPLAY;
          end else begin
            slot_d = pkt_slot_e'(slot_q + 3'd1);
          end
        end
      end
      ST_REPLAY: begin
        if (replay_done_i) begin
          if (remain_q <= CNT_ONE) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            remain_d = remain_q - CNT_ONE;
            state_d  = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SL_OPC;
    end else if (slot_en) begin
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (remain_en) begin
      remain_q <= remain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      seta_q <= '0;
      setb_q <= '0;
    end else if (cfg_en) begin
      opc_q  <= opcode_i;
      seta_q <= setup_a_i;
      setb_q <= setup_b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      max_q <= '0;
    end else if (rect_en) begin
      min_q <= min_w;
      max_q <= max_w;
    end
  end

  // Outputs
  always_comb begin
    rect_ready_o = (state_q == ST_FETCH);
    dw_valid_o   = (state_q == ST_EMIT);
    dw_last_o    = (state_q == ST_EMIT) && (slot_q == LAST_SLOT);
    replay_req_o = (state_q == ST_REPLAY);
    busy_o       = (state_q != ST_IDLE);
    done_o       = done_q;
    error_o      = err_q;
  end

  // R1
  onehot_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rect_ready_o, dw_valid_o, replay_req_o}));

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid_o && !dw_ready_i) |=> (dw_valid_o && $stable(dw_data_o) && $stable(dw_last_o)));

  // R6
  replay_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid_o && dw_ready_i && dw_last_o) |=> replay_req_o);

  // R6
  replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_req_o && !replay_done_i) |=> replay_req_o);

  // R8
  error_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> (done_o && !busy_o && !dw_valid_o && !replay_req_o));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> $stable(opc_q));

endmodule

// File: tb/tb_clip_rect_emitter.sv
`timescale 1ns/1ps
module tb_clip_rect_emitter;

  localparam int CW = 16;
  localparam int NW = 3;

  logic clk, rst_n;
  logic start_i;
  logic [NW-1:0] rect_count_i;
  logic [31:0] opcode_i, setup_a_i, setup_b_i;
  logic rect_valid_i, rect_ready_o;
  logic [CW-1:0] rect_x1_i, rect_y1_i, rect_x2_i, rect_y2_i;
  logic dw_valid_o, dw_ready_i, dw_last_o;
  logic [31:0] dw_data_o;
  logic replay_req_o, replay_done_i;
  logic busy_o, done_o, error_o;

  clip_rect_emitter #(.COORD_W(CW), .CNT_W(NW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rect_count_i(rect_count_i),
    .opcode_i(opcode_i), .setup_a_i(setup_a_i), .setup_b_i(setup_b_i),
    .rect_valid_i(rect_valid_i), .rect_ready_o(rect_ready_o),
    .rect_x1_i(rect_x1_i), .rect_y1_i(rect_y1_i),
    .rect_x2_i(rect_x2_i), .rect_y2_i(rect_y2_i),
    .dw_valid_o(dw_valid_o), .dw_ready_i(dw_ready_i), .dw_data_o(dw_data_o),
    .dw_last_o(dw_last_o), .replay_req_o(replay_req_o), .replay_done_i(replay_done_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic signed [CW-1:0] rx1[8], ry1[8], rx2[8], ry2[8];
  logic [32:0] exp_q[$];
  logic [32:0] got_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit bad_rect(input int i);
    return (rx2[i] <= rx1[i]) || (ry2[i] <= ry1[i]) || (rx2[i] <= 0) || (ry2[i] <= 0);
  endfunction

  // Build the expected word/replay sequence; bit 32 marks a replay.
  task automatic build_exp(input int n, output bit exp_err);
    logic [15:0] xm, ym;
    exp_q.delete();
    exp_err = 1'b0;
    if (n == 0) exp_q.push_back({1'b1, 32'h0});
    for (int i = 0; i < n; i++) begin
      if (bad_rect(i)) begin
        exp_err = 1'b1;
        break;
      end
      xm = rx2[i] - 16'sd1;
      ym = ry2[i] - 16'sd1;
      exp_q.push_back({1'b0, opcode_i});
      exp_q.push_back({1'b0, setup_a_i});
      exp_q.push_back({1'b0, ry1[i], rx1[i]});
      exp_q.push_back({1'b0, ym, xm});
      exp_q.push_back({1'b0, setup_b_i});
      exp_q.push_back({1'b0, 32'h0});
      exp_q.push_back({1'b1, 32'h0});
    end
  endtask

  task automatic run_req(input int n, input bit stall, input bit poke, input string tag);
    bit exp_err, done_seen, hold_pend;
    int ri, post, rep_wait, done_cnt, hold_bad, last_bad, mism;
    logic [31:0] hold_val;
    build_exp(n, exp_err);
    got_q.delete();
    ri = 0; post = 0; rep_wait = 0; done_cnt = 0; hold_bad = 0; last_bad = 0; mism = 0;
    done_seen = 0; hold_pend = 0; hold_val = '0;
    for (int cyc = 0; cyc < 3000 && post < 5; cyc++) begin
      @(negedge clk);
      if (hold_pend && !(dw_valid_o && dw_data_o == hold_val)) hold_bad++;
      start_i      = (cyc == 0) || (poke && cyc == 5);
      rect_count_i = (cyc == 0) ? NW'(n) : 3'd7;
      rect_valid_i = (ri < n);
      rect_x1_i = rx1[ri & 7]; rect_y1_i = ry1[ri & 7];
      rect_x2_i = rx2[ri & 7]; rect_y2_i = ry2[ri & 7];
      dw_ready_i    = stall ? (cyc % 3 != 1) : 1'b1;
      replay_done_i = replay_req_o && (rep_wait >= 1);
      rep_wait      = replay_req_o ? rep_wait + 1 : 0;
      if (rect_ready_o && rect_valid_i) ri++;
      if (dw_valid_o && dw_ready_i) begin
        got_q.push_back({1'b0, dw_data_o});
        if (dw_last_o != ((got_q.size() % 7) == 6 || (got_q.size() > 0 && dw_data_o == 32'h0 && dw_last_o && 0))) last_bad++;
      end
      if (replay_req_o && replay_done_i) begin
        got_q.push_back({1'b1, 32'h0});
        rep_wait = 0;
      end
      hold_pend = dw_valid_o && !dw_ready_i;
      hold_val  = dw_data_o;
      if (done_o) begin done_cnt++; done_seen = 1; end
      if (done_seen) post++;
    end
    start_i = 0; rect_valid_i = 0; replay_done_i = 0;
    chk(done_seen, {tag, " done reached"}, done_seen, 1);
    chk(got_q.size() == exp_q.size(), {tag, " sequence length"}, got_q.size(), exp_q.size());
    foreach (exp_q[i]) if (i < got_q.size() && got_q[i] != exp_q[i] && mism == 0) begin
      mism = 1;
      $display("  mismatch at position %0d", i);
      chk(0, {tag, " sequence content"}, got_q[i], exp_q[i]);
    end
    if (mism == 0) chk(1, {tag, " sequence content"}, 0, 0);
    chk(done_cnt == 1, {tag, " one done pulse"}, done_cnt, 1);
    chk(error_o == exp_err, {tag, " error flag"}, error_o, exp_err);
    chk(!busy_o, {tag, " idle after done"}, busy_o, 0);
    if (n > 0 && !exp_err) chk(last_bad == 0, {tag, " R3 last marker"}, last_bad, 0);
    if (stall) chk(hold_bad == 0, {tag, " R9 hold under backpressure"}, hold_bad, 0);
  endtask

  task automatic set_rect(input int i, input int a, input int b, input int c, input int d);
    rx1[i] = CW'(a); ry1[i] = CW'(b); rx2[i] = CW'(c); ry2[i] = CW'(d);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({busy_o, done_o, error_o, rect_ready_o, dw_valid_o, replay_req_o} == 6'b0,
        "R1 reset idle", {busy_o, done_o, error_o, rect_ready_o, dw_valid_o, replay_req_o}, 0);
  endtask

  task automatic t_single();
    set_rect(0, 10, 20, 110, 220);
    run_req(1, 0, 0, "R3 R4 R5 R6 single");
  endtask

  task automatic t_multi_stall();
    set_rect(0, 0, 0, 1, 1);
    set_rect(1, 100, 5, 200, 300);
    set_rect(2, 7, 8, 9, 10);
    opcode_i = 32'h7D80_0003;
    run_req(3, 1, 1, "R9 R10 R11 three with stalls and busy start");
  endtask

  task automatic t_zero();
    run_req(0, 0, 0, "R7 zero count");
  endtask

  task automatic t_bad_mid();
    set_rect(0, 1, 1, 5, 5);
    set_rect(1, 9, 2, 9, 6);
    set_rect(2, 1, 1, 3, 3);
    run_req(3, 0, 0, "R2 R8 x2 equals x1");
  endtask

  task automatic t_signed();
    set_rect(0, -3, -7, 4, 5);
    set_rect(1, -5, 0, 0, 9);
    run_req(2, 0, 0, "R2 R4 R5 signed and x2 at zero");
  endtask

  task automatic t_bad_y();
    set_rect(0, 0, 3, 4, 3);
    run_req(1, 0, 0, "R2 R8 y2 equals y1");
  endtask

  task automatic t_recover();
    set_rect(0, 2, 2, 4, 4);
    @(negedge clk);
    chk(error_o == 1'b1, "R8 error held until next start", error_o, 1);
    run_req(1, 0, 0, "R8 error cleared by next start");
  endtask

  task automatic t_neg_y();
    set_rect(0, -9, -20, -2, -1);
    run_req(1, 0, 0, "R2 both edges negative");
  endtask

  task automatic t_max();
    for (int i = 0; i < 7; i++) set_rect(i, i, 2 * i, i + 3, 2 * i + 100);
    run_req(7, 0, 0, "R10 largest count");
  endtask

  initial begin
    rst_n = 0; start_i = 0; rect_count_i = '0;
    opcode_i = 32'h7D80_0003; setup_a_i = 32'h1234_5678; setup_b_i = 32'hCAFE_0001;
    rect_valid_i = 0; dw_ready_i = 0; replay_done_i = 0;
    rect_x1_i = '0; rect_y1_i = '0; rect_x2_i = '0; rect_y2_i = '0;
    for (int i = 0; i < 8; i++) set_rect(i, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi_stall();
    t_zero();
    t_bad_mid();
    t_signed();
    t_bad_y();
    t_recover();
    t_neg_y();
    t_max();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule